// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block lets a clocked system read and write an external asynchronous static RAM of 256K words by 16 bits. The RAM has active-low chip select, output enable, write enable and one active-low enable per byte lane. The host raises a request with a word address, write data, a byte-lane mask and a direction flag. The block then steps the RAM strobes through a fixed sequence. Cycle counters time each strobe phase, so every RAM timing minimum is met at the configured clock period. For a read, the block returns the captured data together with a single-cycle acknowledge.

Every timing minimum is a parameter in nanoseconds. The strobe phase lengths are derived from these minimums and the clock period, rounded up to whole cycles. The write-enable window is the smallest width that meets all of these at once: the pulse width, the select-to-end time, the address-to-end time, the lane-enable-to-end time, the data-setup time and the full cycle time.

The data bus is split into an output word, an output-enable and an input word, so the tri-state buffer can sit at the pad. The block keeps the RAM in standby whenever no access is in progress. After a read, it leaves the RAM time to release the bus before it drives write data.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, and whenever no access is in progress, `ram_cs_n`, `ram_oe_n` and `ram_we_n` are 1, `ram_be_n` is all ones, `ram_dq_oe` is 0 and `ack` is 0.
- R2: A read drives `ram_cs_n`=0, `ram_oe_n`=0 and `ram_we_n`=1, with `ram_addr` equal to the requested address. `ram_be_n` is the inverse of `req_mask`: mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8.
- R3: `ram_we_n` is low only while `ram_cs_n` is low and `ram_oe_n` is high, with `ram_be_n` equal to the inverse of `req_mask`. Only lanes whose mask bit is 1 are written.
- R4: The address and lane enables appear one cycle before `ram_cs_n` falls. `ram_cs_n` falls one cycle before `ram_we_n` or `ram_oe_n` falls.
- R5: `ram_we_n` stays low for exactly WR_CYC cycles. WR_CYC is the largest of: ceil(tPWE/T), ceil(tSCS/T)-1, ceil(tAW/T)-2, ceil(tPWB/T)-2, ceil(tSD/T) and ceil(tWC/T)-3. Address, lane enables and write data stay stable during the pulse. `ram_dq_oe` and `ram_cs_n`=0 persist one cycle after `ram_we_n` rises.
- R6: `ram_oe_n` stays low for RD_CYC = max(ceil(tRC/T), ceil(tAA/T)) cycles before data is captured. `rdata` holds the captured value of each enabled lane, and 0 in each disabled lane.
- R7: `ram_dq_oe` is never 1 while `ram_oe_n` is 0, nor within HZ_CYC = ceil(tHZ/T) cycles after `ram_oe_n` rises.
- R8: `ack` is a one-cycle pulse. For a read it comes 3+RD_CYC cycles after the request is sampled, with `rdata` valid. For a write it comes 4+WR_CYC cycles after, as the RAM returns to standby. `rdata` is unchanged by writes.
- R9: After a read acknowledge, a pending request is not accepted for HZ_CYC cycles, so a write that follows a read completes HZ_CYC cycles later than one started from idle.
- R10: A write with an all-zero mask runs the full sequence and is acknowledged, but `ram_be_n` stays all ones and no RAM word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held by the host until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write data |
| req_mask | input | LANES | Lane select, bit 0 = bits 7:0 |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | LANES*LANE_W | Read data, disabled lanes zero |
| ram_addr | output | ADDR_W | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_be_n | output | LANES | RAM lane enables, active low |
| ram_dq_o | output | LANES*LANE_W | Data toward the RAM |
| ram_dq_oe | output | 1 | Pad driver enable for `ram_dq_o` |
| ram_dq_i | input | LANES*LANE_W | Data from the RAM pads |

## Verification
Full-word, lower-only, upper-only and empty masks are applied to both writes and reads. Together they show whether lanes are merged correctly in the RAM, whether disabled lanes read back as zero, and whether an empty write truly leaves memory untouched. Rewriting one address with one lane at a time separates a correct per-lane update from a whole-word overwrite. A read followed at once by a write exercises the bus turnaround and the delayed acceptance. Addresses with the top bits set catch truncation in the address path. A seeded random mix of directions, masks, addresses and idle gaps then measures strobe widths, strobe order and acknowledge latency on every access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SEL,
    ST_RSTB,
    ST_WSTB,
    ST_WHOLD,
    ST_TURN
  } sram_st_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Read strobe length: access from strobes and from address, whole cycles.
  function automatic int rd_cycles(input int clk_ns, input int t_rc, input int t_aa);
    return imax(1, imax(cdiv(t_rc, clk_ns), cdiv(t_aa, clk_ns)));
  endfunction

  // Write-enable window. Address and lane enables lead by two cycles,
  // chip select by one, data is driven with the falling write enable,
  // and one hold cycle follows the rising edge.
  function automatic int wr_cycles(input int clk_ns, input int t_pwe, input int t_scs,
                                   input int t_aw, input int t_pwb, input int t_sd,
                                   input int t_wc);
    int n;
    n = cdiv(t_pwe, clk_ns);
    n = imax(n, cdiv(t_scs, clk_ns) - 1);
    n = imax(n, cdiv(t_aw, clk_ns) - 2);
    n = imax(n, cdiv(t_pwb, clk_ns) - 2);
    n = imax(n, cdiv(t_sd, clk_ns));
    n = imax(n, cdiv(t_wc, clk_ns) - 3);
    return imax(n, 1);
  endfunction

  function automatic int hz_cycles(input int clk_ns, input int t_hz);
    return imax(1, cdiv(t_hz, clk_ns));
  endfunction

endpackage

// File: rtl/sram_step_timer.sv
module sram_step_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 6,
  parameter int WR_CYC = 4,
  parameter int HZ_CYC = 2,
  parameter int TMR_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             accept,
  output logic             release_lanes,
  output logic             capture,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drive,
  output logic             ack
);

  localparam logic [TMR_W-1:0] RD_LOAD = TMR_W'(RD_CYC - 1);
  localparam logic [TMR_W-1:0] WR_LOAD = TMR_W'(WR_CYC - 1);
  localparam logic [TMR_W-1:0] HZ_LOAD = TMR_W'(HZ_CYC - 1);

  sram_st_e st;
  logic     wr_q;

  assign accept        = (st == ST_IDLE) && req && !ack;
  assign capture       = (st == ST_RSTB) && tmr_done;
  assign release_lanes = capture || (st == ST_WHOLD);
  assign tmr_load      = (st == ST_SEL) || capture;
  assign tmr_val       = (st == ST_SEL) ? (wr_q ? WR_LOAD : RD_LOAD) : HZ_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      wr_q  <= 1'b0;
      cs_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      drive <= 1'b0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            wr_q <= req_wr;
            st   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cs_n <= 1'b0;
          st   <= ST_SEL;
        end
        ST_SEL: begin
          if (wr_q) begin
            we_n  <= 1'b0;
            drive <= 1'b1;
            st    <= ST_WSTB;
          end else begin
            oe_n <= 1'b0;
            st   <= ST_RSTB;
          end
        end
        ST_RSTB: begin
          if (tmr_done) begin
            oe_n <= 1'b1;
            cs_n <= 1'b1;
            ack  <= 1'b1;
            st   <= ST_TURN;
          end
        end
        ST_WSTB: begin
          if (tmr_done) begin
            we_n <= 1'b1;
            st   <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          cs_n  <= 1'b1;
          drive <= 1'b0;
          ack   <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_TURN: begin
          if (tmr_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int ADDR_W = 18,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              release_lanes,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [LANES-1:0]  ram_be_n,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (accept)
      addr_q <= req_addr;
  end

  assign ram_addr = addr_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              sel_q;
    logic              be_q;
    logic [LANE_W-1:0] wd_q;
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q <= 1'b0;
        be_q  <= 1'b1;
        wd_q  <= '0;
        rd_q  <= '0;
      end else begin
        if (accept) begin
          sel_q <= req_mask[g];
          be_q  <= ~req_mask[g];
          wd_q  <= req_wdata[g*LANE_W +: LANE_W];
        end else if (release_lanes) begin
          be_q  <= 1'b1;
        end
        if (capture)
          rd_q <= sel_q ? ram_dq_i[g*LANE_W +: LANE_W] : '0;
      end
    end

    assign ram_be_n[g]                   = be_q;
    assign ram_dq_o[g*LANE_W +: LANE_W]  = wd_q;
    assign rdata[g*LANE_W +: LANE_W]     = rd_q;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int LANE_W   = 8,
  parameter int LANES    = 2,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_PWE_NS = 40,
  parameter int T_SCS_NS = 45,
  parameter int T_AW_NS  = 45,
  parameter int T_PWB_NS = 45,
  parameter int T_SD_NS  = 25,
  parameter int T_WC_NS  = 55,
  parameter int T_HZ_NS  = 20,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [LANES-1:0]  ram_be_n,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int RD_CYC  = rd_cycles(CLK_NS, T_RC_NS, T_AA_NS);
  localparam int WR_CYC  = wr_cycles(CLK_NS, T_PWE_NS, T_SCS_NS, T_AW_NS,
                                     T_PWB_NS, T_SD_NS, T_WC_NS);
  localparam int HZ_CYC  = hz_cycles(CLK_NS, T_HZ_NS);
  localparam int MAX_CYC = imax(RD_CYC, imax(WR_CYC, HZ_CYC));
  localparam int TMR_W   = imax(1, $clog2(MAX_CYC + 1));

  logic             accept;
  logic             release_lanes;
  logic             capture;
  logic             tmr_load;
  logic             tmr_done;
  logic [TMR_W-1:0] tmr_val;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC),
    .WR_CYC(WR_CYC),
    .HZ_CYC(HZ_CYC),
    .TMR_W (TMR_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .req_wr       (req_wr),
    .tmr_done     (tmr_done),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .accept       (accept),
    .release_lanes(release_lanes),
    .capture      (capture),
    .cs_n         (ram_cs_n),
    .oe_n         (ram_oe_n),
    .we_n         (ram_we_n),
    .drive        (ram_dq_oe),
    .ack          (ack)
  );

  sram_step_timer #(
    .W(TMR_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  sram_lane_path #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) u_lanes (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .release_lanes(release_lanes),
    .capture      (capture),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_mask     (req_mask),
    .ram_dq_i     (ram_dq_i),
    .ram_addr     (ram_addr),
    .ram_be_n     (ram_be_n),
    .ram_dq_o     (ram_dq_o),
    .rdata        (rdata)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int RD_CYC = 6,
  parameter int WR_CYC = 4,
  parameter int HZ_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_cs_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic [LANES-1:0]  ram_be_n,
  input logic [DATA_W-1:0] ram_dq_o,
  input logic              ram_dq_oe
);

  logic [7:0] we_low_cnt;
  logic [7:0] oe_low_cnt;
  logic [7:0] oe_high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt  <= '0;
      oe_low_cnt  <= '0;
      oe_high_cnt <= 8'hFF;
    end else begin
      we_low_cnt <= ram_we_n ? 8'd0 : we_low_cnt + 8'd1;
      oe_low_cnt <= ram_oe_n ? 8'd0 : oe_low_cnt + 8'd1;
      if (!ram_oe_n)
        oe_high_cnt <= 8'd0;
      else if (oe_high_cnt != 8'hFF)
        oe_high_cnt <= oe_high_cnt + 8'd1;
    end
  end

  p_ack_standby_r1: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && (ram_be_n == '1)));

  p_oe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> (ram_we_n && !ram_cs_n));

  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!ram_cs_n && ram_oe_n));

  p_cs_first_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_cs_n) |-> (ram_we_n && ram_oe_n && $stable(ram_addr) && $stable(ram_be_n)));

  p_we_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> ((we_low_cnt == 8'(WR_CYC)) && ram_dq_oe && !ram_cs_n));

  p_we_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n && !$past(ram_we_n)) |->
      ($stable(ram_addr) && $stable(ram_be_n) && $stable(ram_dq_o)));

  p_oe_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_oe_n) |-> (oe_low_cnt == 8'(RD_CYC)));

  p_bus_turn_r7: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (ram_oe_n && (oe_high_cnt >= 8'(HZ_CYC))));

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LANES (LANES),
  .RD_CYC(RD_CYC),
  .WR_CYC(WR_CYC),
  .HZ_CYC(HZ_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (ack),
  .ram_addr (ram_addr),
  .ram_cs_n (ram_cs_n),
  .ram_oe_n (ram_oe_n),
  .ram_we_n (ram_we_n),
  .ram_be_n (ram_be_n),
  .ram_dq_o (ram_dq_o),
  .ram_dq_oe(ram_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int CLK_NS = 8;
  localparam int ADDR_W = 18;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DW     = LANES * LANE_W;

  function automatic int up(input int a);
    return (a + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Phase lengths computed from the requirement formulas (R5, R6, R7).
  localparam int RD_C = mx(up(55), up(55));
  localparam int WR_C = mx(mx(mx(up(40), up(45) - 1), mx(up(45) - 2, up(45) - 2)),
                           mx(up(25), up(55) - 3));
  localparam int HZ_C = up(20);

  logic              clk, rst;
  logic              req, req_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [DW-1:0]     req_wdata;
  logic [LANES-1:0]  req_mask;
  logic              ack;
  logic [DW-1:0]     rdata;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [LANES-1:0]  ram_be_n;
  logic [DW-1:0]     ram_dq_o, ram_dq_i;

  sram_async_ctrl #(.CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .ack(ack), .rdata(rdata),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_be_n(ram_be_n), .ram_dq_o(ram_dq_o),
    .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // RAM model (indexed by the low 8 address bits) and bench reference copy
  logic [DW-1:0]     ram     [0:255];
  logic [DW-1:0]     ref_mem [0:255];
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_mask;
  logic [DW-1:0]     last_rd;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (!ram_cs_n && !ram_oe_n && ram_we_n && !ram_be_n[l])
        ram_dq_i[l*LANE_W +: LANE_W] = ram[ram_addr[7:0]][l*LANE_W +: LANE_W];
      else
        ram_dq_i[l*LANE_W +: LANE_W] = 8'h5A;
    end
  end

  // Pad-side monitor, sampled at the falling edge
  logic              p_cs, p_we, p_oe;
  logic [LANES-1:0]  p_be;
  logic [ADDR_W-1:0] p_addr;
  int we_cnt, oe_cnt, oe_hi, cs_cnt;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) ram[i] = 16'(i * 16'h0101) ^ 16'h3C3C;
      p_cs = 1; p_we = 1; p_oe = 1; p_be = '1; p_addr = '0;
      we_cnt = 0; oe_cnt = 0; oe_hi = 100; cs_cnt = 0;
    end else begin
      cs_cnt = ram_cs_n ? 0 : cs_cnt + 1;
      oe_hi  = !ram_oe_n ? 0 : ((oe_hi < 100) ? oe_hi + 1 : 100);
      if (p_cs && !ram_cs_n)   // R4: address and lanes lead chip select
        chk(ram_be_n == p_be && ram_addr == p_addr && ram_addr == cur_addr &&
            ram_be_n == ~cur_mask && ram_we_n && ram_oe_n,
            "R4 order at select", {ram_be_n, p_be}, {~cur_mask, ~cur_mask});
      if ((p_we && !ram_we_n) || (p_oe && !ram_oe_n))
        chk(cs_cnt == 2, "R4 select leads strobe", cs_cnt, 2);
      if (p_oe && !ram_oe_n)
        chk(ram_we_n && ram_be_n == ~cur_mask && ram_addr == cur_addr,
            "R2 read strobes", ram_addr, cur_addr);
      if (p_we && !ram_we_n)
        chk(ram_oe_n && oe_hi >= HZ_C && ram_dq_oe, "R7 turnaround before drive",
            oe_hi, HZ_C);
      if (ram_dq_oe && (!ram_oe_n || oe_hi < HZ_C))
        chk(0, "R7 drive against RAM", oe_hi, HZ_C);
      if (!ram_we_n && (ram_cs_n || !ram_oe_n))
        chk(0, "R3 write outside select", {ram_cs_n, ram_oe_n}, 2'b01);
      if (!p_oe && ram_oe_n)
        chk(oe_cnt == RD_C, "R6 read strobe width", oe_cnt, RD_C);
      if (!p_we && ram_we_n) begin
        chk(we_cnt == WR_C && ram_dq_oe && !ram_cs_n && ram_oe_n &&
            ram_addr == cur_addr && ram_be_n == ~cur_mask,
            "R5 write window and hold", we_cnt, WR_C);
        for (int l = 0; l < LANES; l++)
          if (!ram_be_n[l])
            ram[ram_addr[7:0]][l*LANE_W +: LANE_W] = ram_dq_o[l*LANE_W +: LANE_W];
      end
      we_cnt = ram_we_n ? 0 : we_cnt + 1;
      oe_cnt = ram_oe_n ? 0 : oe_cnt + 1;
      p_cs = ram_cs_n; p_we = ram_we_n; p_oe = ram_oe_n;
      p_be = ram_be_n; p_addr = ram_addr;
    end
  end

  function automatic logic [DW-1:0] exp_read(input logic [ADDR_W-1:0] a,
                                             input logic [LANES-1:0] m);
    logic [DW-1:0] v;
    for (int l = 0; l < LANES; l++)
      v[l*LANE_W +: LANE_W] = m[l] ? ref_mem[a[7:0]][l*LANE_W +: LANE_W] : '0;
    return v;
  endfunction

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(ram_cs_n && ram_we_n && ram_oe_n && ram_be_n == 2'b11 && !ram_dq_oe && !ack,
          "R1 idle standby", {ram_cs_n, ram_we_n, ram_oe_n, ram_be_n, ram_dq_oe, ack},
          7'b1111100);
    end
  endtask

  // Called at a falling edge; returns at the falling edge that shows ack.
  task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [DW-1:0] d, input logic [LANES-1:0] m,
                        input int extra);
    int  k;
    bit  got;
    int  lat;
    logic [DW-1:0] e;
    cur_addr = a; cur_mask = m;
    req_wr = wr; req_addr = a; req_wdata = d; req_mask = m; req = 1'b1;
    k = 0; got = 0;
    while (!got && k < 200) begin
      @(negedge clk);
      k++;
      if (ack) got = 1;
    end
    req = 1'b0;
    lat = (wr ? 4 + WR_C : 3 + RD_C) + extra;
    chk(got && k == lat, wr ? "R8 write ack latency" : "R8 read ack latency", k, lat);
    if (wr) begin
      for (int l = 0; l < LANES; l++)
        if (m[l]) ref_mem[a[7:0]][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      chk(rdata == last_rd, "R8 rdata held over write", rdata, last_rd);
    end else begin
      e = exp_read(a, m);
      chk(rdata == e, "R6 read data per lane", rdata, e);
      last_rd = e;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int dummy;
    rst = 1; req = 0; req_wr = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    last_rd = '0; cur_addr = '0; cur_mask = '0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 16'(i * 16'h0101) ^ 16'h3C3C;
    dummy = $urandom(32'd7151);
    repeat (3) @(negedge clk);
    chk(ram_cs_n && ram_we_n && ram_oe_n && ram_be_n == 2'b11 && !ram_dq_oe && !ack,
        "R1 reset state", {ram_cs_n, ram_we_n, ram_oe_n, ram_be_n}, 5'b11111);
    rst = 0;
    idle_gap(2);

    // R3/R6: full word write and read back
    access(1, 18'h00012, 16'hBEEF, 2'b11, 0); idle_gap(2);
    access(0, 18'h00012, 16'h0000, 2'b11, 0); idle_gap(3);
    // R3: lower lane only, upper must survive
    access(1, 18'h00012, 16'h1234, 2'b01, 0); idle_gap(2);
    access(0, 18'h00012, 16'h0000, 2'b11, 0); idle_gap(3);
    chk(last_rd == 16'hBE34, "R3 lower-lane merge", last_rd, 16'hBE34);
    // R3/R6: upper lane write, lower-only read returns zero upper byte
    access(1, 18'h00012, 16'hA5C3, 2'b10, 0); idle_gap(2);
    access(0, 18'h00012, 16'h0000, 2'b01, 0); idle_gap(3);
    chk(last_rd == 16'h0034, "R6 disabled lane reads zero", last_rd, 16'h0034);
    // R10: empty-mask write changes nothing
    access(1, 18'h00012, 16'h0000, 2'b00, 0); idle_gap(2);
    access(0, 18'h00012, 16'h0000, 2'b11, 0); idle_gap(3);
    chk(last_rd == 16'hA534, "R10 empty mask leaves word", last_rd, 16'hA534);
    // R2: top address bits reach the pads
    access(1, 18'h3FFFF, 16'h7E81, 2'b11, 0); idle_gap(2);
    access(0, 18'h3FFFF, 16'h0000, 2'b11, 0);
    // R9: write queued right behind a read waits out the turnaround
    access(1, 18'h2AB40, 16'hC0DE, 2'b11, HZ_C); idle_gap(2);
    access(0, 18'h2AB40, 16'h0000, 2'b10, 0); idle_gap(3);

    for (int it = 0; it < 160; it++) begin
      bit               w;
      logic [ADDR_W-1:0] a;
      w = $urandom() % 2;
      a = ADDR_W'($urandom());
      access(w, a, DW'($urandom()), LANES'($urandom()), 0);
      idle_gap(w ? 1 + ($urandom() % 3) : HZ_C + 1 + ($urandom() % 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule